// File: doc/BRIEF.md
# Push-Button Programmable Square-Wave Generator

The block produces a two-level square wave whose frequency, in kHz, equals an 8-bit setting held inside the block. Two push-button inputs move the setting: one steps it up, the other steps it down. The setting is always visible in plain binary on an 8-bit LED bus. A quick press moves the setting by exactly one. Holding a button past a hold threshold makes the setting keep stepping in that direction at a fixed repeat interval until the button is let go.

Each raw button passes through a two-flop synchronizer and a debouncer. The debouncer adopts a new level only after it has stayed steady for a set number of cycles. A stepper turns the clean levels into single steps and auto-repeat steps, and it clamps the setting at both ends. A synthesizer divides the system clock down to a 1 MHz tick. On every tick it adds the setting to a modulo-1000 phase accumulator, and it drives the output high while the accumulator is in the lower half of its range.

All times are parameters given in clock cycles. This lets a simulation shorten them while the hardware keeps 10 ms debounce, 1 s hold and 100 ms repeat at 50 MHz.

Top module: `khz_pulse_gen`

## Requirements
- R1: After reset is released, `led_o` reads 0 and `pulse_o` is low.
- R2: `led_o[i]` is bit i of the current setting, with bit 0 the least significant, so the bus reads the setting in unsigned binary.
- R3: A press of `btn_up_i` shorter than the hold threshold raises the setting by exactly one. A press of `btn_dn_i` shorter than the hold threshold lowers it by exactly one.
- R4: A button level that lasts fewer than `DEBOUNCE_CYC` cycles after synchronization produces no step.
- R5: While one button stays pressed, counting cycles k from the cycle the debounced level rises, steps occur at k = 0, k = `HOLD_CYC`, and then every `REPEAT_CYC` cycles after that. A hold that lasts N debounced cycles therefore yields 1 step when N ≤ `HOLD_CYC`. Otherwise it yields 2 + floor((N−1−`HOLD_CYC`)/`REPEAT_CYC`) steps.
- R6: The setting saturates. Stepping up at 255 leaves it at 255, stepping down at 0 leaves it at 0, and it never wraps. Between clock cycles it changes by at most one.
- R7: While both debounced buttons are pressed, the setting does not change.
- R8: With the tick at `TICK_HZ`, any window of `TICK_HZ/1000` consecutive ticks contains exactly as many rising edges of `pulse_o` as the setting value. The accumulator always stays below `TICK_HZ/1000`.
- R9: While the setting is 0, `pulse_o` is low (one cycle after the setting reaches 0) and the accumulator is held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, `CLK_HZ` Hz |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| btn_up_i | input | 1 | Raw increment button, high while pressed |
| btn_dn_i | input | 1 | Raw decrement button, high while pressed |
| pulse_o | output | 1 | Square-wave output at the set frequency in kHz |
| led_o | output | 8 | Current frequency setting in unsigned binary |

## Verification
The bound checker enforces four rules on every clock cycle:
- the setting moves by at most one step between cycles, with no wrap (R6);
- the setting stays frozen while both buttons are held (R7);
- the output is low once the setting is zero (R9);
- the accumulator stays inside its modulus (R8).

Some properties span hundreds of cycles, and only the bench's scenarios can show them: the exact number of steps produced by a press of a given length, the rejection of short glitches, and the count of output rising edges over a full accumulator period. The bench sweeps the setting across its range one press at a time with a shortened timing configuration. It compares the LED value after each press and, at regular intervals and at both ends, the measured edge count against the setting.

// File: rtl/kpg_pkg.sv
package kpg_pkg;

  // Which single direction the debounced buttons currently request.
  typedef enum logic [1:0] {
    SEL_IDLE = 2'b00,
    SEL_UP   = 2'b01,
    SEL_DN   = 2'b10
  } sel_e;

  // Hold timer phase: waiting for the hold threshold, or auto-repeating.
  typedef enum logic {
    PH_DELAY  = 1'b0,
    PH_REPEAT = 1'b1
  } phase_e;

endpackage

// File: rtl/kpg_rst_sync.sv
module kpg_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/kpg_button.sv
module kpg_button #(
  parameter int unsigned DEBOUNCE_CYC = 500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o
);

  localparam int unsigned CNT_W = (DEBOUNCE_CYC < 2) ? 1 : $clog2(DEBOUNCE_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYC - 1);

  logic [1:0]       sync_q;
  logic             level_q, level_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // two-flop synchronizer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], raw_i};
  end

  // the level is adopted only after DEBOUNCE_CYC steady cycles of difference
  always_comb begin
    level_d = level_q;
    cnt_d   = cnt_q;
    if (sync_q[1] == level_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      level_d = sync_q[1];
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level_o = level_q;

endmodule

// File: rtl/kpg_stepper.sv
module kpg_stepper
  import kpg_pkg::*;
#(
  parameter int unsigned W          = 8,
  parameter int unsigned HOLD_CYC   = 50_000_000,
  parameter int unsigned REPEAT_CYC = 5_000_000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] setting_o
);

  localparam int unsigned LONGEST = (HOLD_CYC > REPEAT_CYC) ? HOLD_CYC : REPEAT_CYC;
  localparam int unsigned TMR_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);
  localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] REP_LAST  = TMR_W'(REPEAT_CYC - 1);
  localparam logic [W-1:0]     SET_MAX   = {W{1'b1}};

  sel_e             sel_q, sel_d;
  phase_e           phase_q, phase_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [W-1:0]     set_q, set_d;
  logic             step;

  always_comb begin
    if (up_i && !dn_i)      sel_d = SEL_UP;
    else if (dn_i && !up_i) sel_d = SEL_DN;
    else                    sel_d = SEL_IDLE;
  end

  // hold timer: step on entry, after the hold threshold, then at each repeat interval
  always_comb begin
    step    = 1'b0;
    tmr_d   = '0;
    phase_d = PH_DELAY;
    if (sel_d != SEL_IDLE) begin
      if (sel_d != sel_q) begin
        step = 1'b1;
      end else if (tmr_q == ((phase_q == PH_REPEAT) ? REP_LAST : HOLD_LAST)) begin
        step    = 1'b1;
        phase_d = PH_REPEAT;
      end else begin
        tmr_d   = tmr_q + 1'b1;
        phase_d = phase_q;
      end
    end
  end

  // saturating setting register
  always_comb begin
    set_d = set_q;
    if (step) begin
      if (sel_d == SEL_UP) begin
        if (set_q != SET_MAX) set_d = set_q + 1'b1;
      end else begin
        if (set_q != '0) set_d = set_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= SEL_IDLE;
      phase_q <= PH_DELAY;
      tmr_q   <= '0;
      set_q   <= '0;
    end else begin
      sel_q   <= sel_d;
      phase_q <= phase_d;
      tmr_q   <= tmr_d;
      set_q   <= set_d;
    end
  end

  assign setting_o = set_q;

endmodule

// File: rtl/kpg_synth.sv
module kpg_synth #(
  parameter int unsigned W       = 8,
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_HZ = 1_000_000,
  parameter int unsigned ACC_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     setting_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             pulse_o
);

  localparam int unsigned DIV     = CLK_HZ / TICK_HZ;
  localparam int unsigned ACC_MOD = TICK_HZ / 1000;
  localparam int unsigned HALF    = ACC_MOD / 2;
  localparam int unsigned SUM_W   = ACC_W + 1;

  logic             tick;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] sum;
  logic             pulse_q, pulse_d;

  generate
    if (DIV <= 1) begin : g_tick_every
      assign tick = 1'b1;
    end else begin : g_tick_div
      localparam int unsigned DIV_W = $clog2(DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
      logic [DIV_W-1:0] div_q, div_d;

      always_comb begin
        div_d = (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
      end

      assign tick = (div_q == DIV_LAST);
    end
  endgenerate

  // phase accumulator modulo ACC_MOD, held at zero while the setting is zero
  always_comb begin
    sum   = SUM_W'(acc_q) + SUM_W'(setting_i);
    acc_d = acc_q;
    if (setting_i == '0) begin
      acc_d = '0;
    end else if (tick) begin
      if (sum >= SUM_W'(ACC_MOD)) acc_d = ACC_W'(sum - SUM_W'(ACC_MOD));
      else                        acc_d = ACC_W'(sum);
    end
    pulse_d = (setting_i != '0) && (acc_q < ACC_W'(HALF));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      pulse_q <= pulse_d;
    end
  end

  assign acc_o   = acc_q;
  assign pulse_o = pulse_q;

endmodule

// File: rtl/khz_pulse_gen.sv
module khz_pulse_gen #(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned TICK_HZ      = 1_000_000,
  parameter int unsigned DEBOUNCE_CYC = 500_000,
  parameter int unsigned HOLD_CYC     = 50_000_000,
  parameter int unsigned REPEAT_CYC   = 5_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       btn_up_i,
  input  logic       btn_dn_i,
  output logic       pulse_o,
  output logic [7:0] led_o
);

  localparam int unsigned W       = 8;
  localparam int unsigned ACC_MOD = TICK_HZ / 1000;
  localparam int unsigned ACC_W   = $clog2(ACC_MOD + (1 << W));

  logic             rst_n;
  logic             up_lvl, dn_lvl;
  logic [W-1:0]     setting;
  logic [ACC_W-1:0] acc;

  kpg_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  kpg_button #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_btn_up (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .raw_i   (btn_up_i),
    .level_o (up_lvl)
  );

  kpg_button #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_btn_dn (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .raw_i   (btn_dn_i),
    .level_o (dn_lvl)
  );

  kpg_stepper #(
    .W          (W),
    .HOLD_CYC   (HOLD_CYC),
    .REPEAT_CYC (REPEAT_CYC)
  ) u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .up_i      (up_lvl),
    .dn_i      (dn_lvl),
    .setting_o (setting)
  );

  kpg_synth #(
    .W       (W),
    .CLK_HZ  (CLK_HZ),
    .TICK_HZ (TICK_HZ),
    .ACC_W   (ACC_W)
  ) u_synth (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .setting_i (setting),
    .acc_o     (acc),
    .pulse_o   (pulse_o)
  );

  assign led_o = setting;

endmodule

// File: rtl/kpg_checker.sv
module kpg_checker #(
  parameter int unsigned ACC_W   = 10,
  parameter int unsigned ACC_MOD = 1000
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             up_lvl,
  input logic             dn_lvl,
  input logic [7:0]       led_o,
  input logic             pulse_o,
  input logic [ACC_W-1:0] acc
);

  // R6
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (led_o != $past(led_o)) |->
      ((led_o == $past(led_o) + 8'd1) && ($past(led_o) != 8'd255)) ||
      ((led_o == $past(led_o) - 8'd1) && ($past(led_o) != 8'd0)));

  // R7
  both_held_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (up_lvl && dn_lvl) |=> $stable(led_o));

  // R9
  zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (led_o == 8'd0) |=> (!pulse_o && (acc == '0)));

  // R8
  acc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    acc < ACC_W'(ACC_MOD));

endmodule

bind khz_pulse_gen kpg_checker #(.ACC_W(ACC_W), .ACC_MOD(ACC_MOD)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n),
  .up_lvl  (up_lvl),
  .dn_lvl  (dn_lvl),
  .led_o   (led_o),
  .pulse_o (pulse_o),
  .acc     (acc)
);

// File: tb/tb_khz_pulse_gen.sv
module tb_khz_pulse_gen;

  // Shortened configuration: one tick per clock, modulo-1000 accumulator.
  localparam int unsigned DEB  = 4;
  localparam int unsigned HOLD = 200;
  localparam int unsigned REP  = 20;

  logic       clk;
  logic       rst_n;
  logic       up, dn;
  logic       pulse;
  logic [7:0] led;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_set = 0;
  bit done = 0;

  khz_pulse_gen #(
    .CLK_HZ       (1_000_000),
    .TICK_HZ      (1_000_000),
    .DEBOUNCE_CYC (DEB),
    .HOLD_CYC     (HOLD),
    .REPEAT_CYC   (REP)
  ) dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .btn_up_i (up),
    .btn_dn_i (dn),
    .pulse_o  (pulse),
    .led_o    (led)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(input bit u, input bit d, input int cycles);
    @(negedge clk);
    up = u;
    dn = d;
    repeat (cycles) @(negedge clk);
    up = 1'b0;
    dn = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  // rising edges and high cycles over one full accumulator period (1000 ticks)
  task automatic measure(output int rises, output int highs);
    logic prev;
    repeat (10) @(negedge clk);
    prev  = pulse;
    rises = 0;
    highs = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (pulse && !prev) rises++;
      if (pulse) highs++;
      prev = pulse;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int r, h;
    up = 1'b0;
    dn = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 led", led, 0);
    check("R1 pulse", pulse, 0);

    // R9 quiet output at zero
    measure(r, h);
    check("R9 highs at zero", h, 0);

    // R4 glitch shorter than debounce
    press(1'b1, 1'b0, DEB - 2);
    check("R4 glitch up", led, 0);

    // R6 down at floor
    press(1'b0, 1'b1, 30);
    check("R6 floor hold", led, 0);

    // R3 single steps
    for (int k = 0; k < 3; k++) press(1'b1, 1'b0, 30);
    check("R3 three ups", led, 3);
    press(1'b0, 1'b1, 30);
    check("R3 one down", led, 2);

    // R7 both pressed together
    press(1'b1, 1'b1, 60);
    check("R7 both pressed", led, 2);

    // R5 hold N = HOLD + 5*REP + 10 -> 7 steps
    press(1'b1, 1'b0, HOLD + 5 * REP + 10);
    check("R5 auto repeat", led, 9);
    exp_set = 9;

    // R8 / R2 sweep by single presses up to the ceiling
    measure(r, h);
    check("R8 rises at 9", r, 9);
    while (exp_set < 255) begin
      press(1'b1, 1'b0, 30);
      exp_set++;
      check("R2 led binary", led, exp_set);
      check("R2 led bit0", int'(led[0]), exp_set % 2);
      if (exp_set % 6 == 0 || exp_set == 255) begin
        measure(r, h);
        check("R8 rise count", r, exp_set);
      end
    end

    // R6 ceiling
    press(1'b1, 1'b0, 30);
    check("R6 ceiling press", led, 255);
    press(1'b1, 1'b0, HOLD + 3 * REP + 5);
    check("R6 ceiling hold", led, 255);

    // R6 long hold down to floor, R5 repeat count is ample
    press(1'b0, 1'b1, HOLD + 260 * REP);
    check("R6 floor after hold", led, 0);
    press(1'b0, 1'b1, 30);
    check("R6 floor press", led, 0);

    // R9 back at zero
    measure(r, h);
    check("R9 rises at zero", r, 0);
    check("R9 highs at zero again", h, 0);

    done = 1;
    finish_run();
  end

endmodule